// File: doc/BRIEF.md
# Accumulator Fractional-N Clock Divider

This block divides a fast clock by a ratio that can take a fractional value. A down-counter sets the length of each output period. A first-order phase accumulator then picks, period by period, whether that length is the integer modulus N or N+1. Each time the divider wraps, the accumulator adds the fractional word K modulo 2^K_W. When that sum carries out, the period that starts at the same edge is one fast cycle longer. Over many periods the average ratio is N + K/2^K_W. With the default 22-bit fraction, the step between ratios is fine enough to set the frequency to within about ten hertz for any ratio of bit rate to reference.

The output is a stream of one-cycle pulses, one at the end of each division count, and it feeds a phase/frequency comparator. The lowest bit of the fraction is always taken as 1. This keeps the fraction odd, so the accumulator runs through all 2^K_W states before it repeats and never settles into a short limit cycle. Software therefore has 21 free bits. N and K are read only when a period ends, and values below the minimum modulus are raised to 2.

Top module: `frac_n_div`

## Requirements
- R1: While rst_ni is low, pulse_o is 0 and the accumulator holds zero. The first pulse appears in the cycle after the first rising clock edge that follows the release of reset.
- R2: The fraction in effect is k_i with bit 0 forced to 1, so an even k_i acts exactly like k_i+1.
- R3: At each wrap the accumulator adds the effective fraction modulo 2^K_W. If that sum carries out, the period that starts at the same edge lasts N+1 fast cycles. Otherwise it lasts N fast cycles.
- R4: Over any 2^K_W consecutive periods, exactly K_eff of them have length N+1, where K_eff is the effective fraction.
- R5: pulse_o is high for exactly one fast-clock cycle per period, and consecutive pulses are separated by the period length.
- R6: n_i and k_i are sampled only at the wrap edge. A change made in the middle of a period does not alter that period and takes effect from the next period.
- R7: An n_i value below 2 is treated as 2.
- R8: With an effective fraction of 1 and the accumulator starting from zero, every period is exactly N long until the accumulator wraps after 2^K_W periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock being divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| n_i | input | N_W | Integer modulus N |
| k_i | input | K_W | Fractional word; bit 0 is ignored and treated as 1 |
| pulse_o | output | 1 | One-cycle pulse at the end of each division count |

## Verification
On every cycle, the assertions check the following:
- the pulse is one cycle wide;
- the accumulator and the active configuration do not change between wraps;
- the accumulator's low bit toggles at every wrap, which shows that an odd fraction is in effect;
- the registered carry agrees with the accumulator wrapping around;
- the gap between pulses equals the latched modulus plus carry;
- the active modulus is never below 2.

Some behaviours can only be shown by the bench's scenarios:
- the exact interval sequence that follows from a given fraction;
- the count of long periods over a full accumulator cycle, checked on a narrow instance;
- the effect of forcing an even fraction to odd;
- the moment at which a configuration changed mid-period takes effect.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  localparam int unsigned FND_MIN_MOD = 2;
endpackage

// File: rtl/fnd_cfg.sv
module fnd_cfg #(
  parameter int unsigned N_W = 8,
  parameter int unsigned K_W = 22
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [N_W-1:0] n_i,
  input  logic [K_W-1:0] k_i,
  output logic [N_W-1:0] n_eff_o,
  output logic [K_W-1:0] k_eff_o,
  output logic [N_W-1:0] n_q_o,
  output logic [K_W-1:0] k_q_o
);
  localparam logic [N_W-1:0] MIN_N = N_W'(fnd_pkg::FND_MIN_MOD);

  assign n_eff_o = (n_i < MIN_N) ? MIN_N : n_i;
  // odd fraction keeps the accumulator on its full-length cycle
  assign k_eff_o = {k_i[K_W-1:1], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q_o <= MIN_N;
      k_q_o <= K_W'(1);
    end else if (load_i) begin
      n_q_o <= n_eff_o;
      k_q_o <= k_eff_o;
    end
  end
endmodule

// File: rtl/fnd_acc.sv
module fnd_acc #(
  parameter int unsigned K_W = 22
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  input  logic [K_W-1:0] k_i,
  output logic           carry_o,
  output logic [K_W-1:0] acc_o,
  output logic           carry_q_o
);
  logic [K_W:0]   sum;
  logic [K_W-1:0] acc_q;

  assign sum     = {1'b0, acc_q} + {1'b0, k_i};
  assign carry_o = sum[K_W];
  assign acc_o   = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      carry_q_o <= 1'b0;
    end else if (step_i) begin
      acc_q     <= sum[K_W-1:0];
      carry_q_o <= sum[K_W];
    end
  end
endmodule

// File: rtl/fnd_cnt.sv
module fnd_cnt #(
  parameter int unsigned N_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] n_i,
  input  logic           ext_i,
  output logic           wrap_o,
  output logic           pulse_o
);
  logic [N_W:0]   len;
  logic [N_W:0]   load_w;
  logic [N_W-1:0] cnt_q;

  assign len    = {1'b0, n_i} + (N_W+1)'(ext_i);
  assign load_w = len - (N_W+1)'(1);
  assign wrap_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= wrap_o;
      if (wrap_o) cnt_q <= load_w[N_W-1:0];
      else        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/frac_n_div.sv
module frac_n_div #(
  parameter int unsigned N_W = 8,
  parameter int unsigned K_W = 22
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] n_i,
  input  logic [K_W-1:0] k_i,
  output logic           pulse_o
);
  logic           wrap;
  logic           carry;
  logic           carry_q;
  logic [N_W-1:0] n_eff;
  logic [K_W-1:0] k_eff;
  logic [N_W-1:0] n_q;
  logic [K_W-1:0] k_q;
  logic [K_W-1:0] acc_q;

  fnd_cfg #(.N_W(N_W), .K_W(K_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wrap),
    .n_i    (n_i),
    .k_i    (k_i),
    .n_eff_o(n_eff),
    .k_eff_o(k_eff),
    .n_q_o  (n_q),
    .k_q_o  (k_q)
  );

  fnd_acc #(.K_W(K_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (wrap),
    .k_i      (k_eff),
    .carry_o  (carry),
    .acc_o    (acc_q),
    .carry_q_o(carry_q)
  );

  fnd_cnt #(.N_W(N_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .n_i    (n_eff),
    .ext_i  (carry),
    .wrap_o (wrap),
    .pulse_o(pulse_o)
  );
endmodule

// File: rtl/frac_n_div_chk.sv
module frac_n_div_chk #(
  parameter int unsigned N_W = 8,
  parameter int unsigned K_W = 22
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           pulse_o,
  input logic [K_W-1:0] acc_q,
  input logic           carry_q,
  input logic [N_W-1:0] n_q,
  input logic [K_W-1:0] k_q
);
  logic [N_W+1:0] gap_q;
  logic [N_W+1:0] len_q;
  logic           have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      len_q  <= '0;
      have_q <= 1'b0;
    end else if (pulse_o) begin
      gap_q  <= (N_W+2)'(1);
      len_q  <= {2'b00, n_q} + (N_W+2)'(carry_q);
      have_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  assert_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  assert_pulse_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && have_q) |-> (gap_q == len_q));
  assert_acc_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_o |-> $stable(acc_q));
  assert_cfg_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_o |-> ($stable(n_q) && $stable(k_q)));
  assert_lsb_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (acc_q[0] != $past(acc_q[0])));
  assert_carry_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (carry_q == (acc_q < $past(acc_q))));
  assert_min_mod_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (n_q >= N_W'(2)));
endmodule

bind frac_n_div frac_n_div_chk #(.N_W(N_W), .K_W(K_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pulse_o(pulse_o),
  .acc_q  (acc_q),
  .carry_q(carry_q),
  .n_q    (n_q),
  .k_q    (k_q)
);

// File: tb/test_frac_n_div.sv
module test_frac_n_div;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  n_in = 8'd4;
  logic [21:0] k_in = 22'd0;
  logic        pulse;
  logic [3:0]  n_sm = 4'd3;
  logic [5:0]  k_sm = 6'd16;
  logic        pulse_sm;

  int checks = 0;
  int fails  = 0;
  logic [21:0] acc_m = '0;
  int exp_len = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_n_div i_frac_n_div (
    .clk_i(clk), .rst_ni(rst_n), .n_i(n_in), .k_i(k_in), .pulse_o(pulse));

  frac_n_div #(.N_W(4), .K_W(6)) i_frac_n_div_small (
    .clk_i(clk), .rst_ni(rst_n), .n_i(n_sm), .k_i(k_sm), .pulse_o(pulse_sm));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model of one wrap: accumulate effective fraction, return the next period length
  function automatic int step(input int n, input logic [21:0] k);
    logic [22:0] s;
    s = {1'b0, acc_m} + {1'b0, k | 22'd1};
    acc_m = s[21:0];
    return ((n < 2) ? 2 : n) + int'(s[22]);
  endfunction

  // called at the negedge of a pulse; returns cycles to the next pulse
  task automatic gap_to_next(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!pulse && g < 1000);
  endtask

  task automatic period(input int n, input logic [21:0] k, input string req);
    int cur, g;
    cur = exp_len;
    n_in = 8'(n);
    k_in = k;
    exp_len = step(n, k);
    gap_to_next(g);
    check(g == cur, req, g, cur);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    n_in = 8'd4; k_in = 22'd0;
    repeat (4) @(negedge clk);
    check(pulse == 1'b0, "R1 pulse low in reset", int'(pulse), 0);
    check(pulse_sm == 1'b0, "R1 small pulse low in reset", int'(pulse_sm), 0);
    acc_m = '0;
    rst_n = 1'b1;
    exp_len = step(4, 22'd0);
    @(negedge clk);
    check(pulse == 1'b1, "R1 first pulse after first edge", int'(pulse), 1);
  endtask

  task automatic t_integer;
    for (int i = 0; i < 12; i++) period(4, 22'd0, "R8 integer period");
  endtask

  task automatic t_model;
    for (int i = 0; i < 40; i++) period(6, 22'h2AAAAA, "R3 R2 accumulator pattern");
  endtask

  task automatic t_half;
    for (int i = 0; i < 20; i++) period(3, 22'h200000, "R3 half fraction");
  endtask

  task automatic t_clamp;
    for (int i = 0; i < 10; i++) period(0, 22'h3FFFFE, "R7 n=0 clamp");
    for (int i = 0; i < 10; i++) period(1, 22'h3FFFFE, "R7 n=1 clamp");
  endtask

  task automatic t_midchange;
    int cur, g;
    for (int i = 0; i < 3; i++) period(3, 22'd0, "R6 settle");
    for (int r = 0; r < 4; r++) begin
      cur = exp_len;
      @(negedge clk);
      n_in = (r % 2 == 0) ? 8'd9 : 8'd3;
      k_in = 22'h155555;
      exp_len = step(int'(n_in), k_in);
      g = 1;
      while (!pulse && g < 1000) begin
        @(negedge clk);
        g++;
      end
      check(g == cur, "R6 mid-period change", g, cur);
    end
  endtask

  task automatic t_full_small;
    int g, lng;
    g = 0;
    while (!pulse_sm && g < 100) begin
      @(negedge clk);
      g++;
    end
    for (int w = 0; w < 2; w++) begin
      lng = 0;
      for (int i = 0; i < 64; i++) begin
        g = 0;
        do begin
          @(negedge clk);
          g++;
        end while (!pulse_sm && g < 100);
        if (g == 4) lng++;
        if (i % 16 == 0) check(g == 3 || g == 4, "R3 R5 small period length", g, 3);
      end
      check(lng == 17, "R4 R2 long periods over full cycle", lng, 17);
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_integer();
    t_model();
    t_half();
    t_clamp();
    t_midchange();
    t_full_small();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule